// File: doc/BRIEF.md
# Matrix Keypad Scan Engine

This block scans a keypad matrix of up to 16 rows and 8 columns from a slow scan clock. It pulls one configured row low at a time, in ascending order, and samples the column inputs. Every row is held for a base time plus a programmable debounce count. A key counts as pressed only if its column reads asserted on every sample of that row's debounce window. Each pressed key leaves the block as an 8-bit entry, one per cycle, ready to be pushed into a downstream key queue.

A pass opens with a fixed five-cycle lead-in, visits every configured row, and closes with a programmable gap before the next pass. Clearing the enable input stops scanning at once. While scanning is stopped, the block drives every configured row that holds at least one unmasked key. It raises a wake request when a column of such a key reads asserted. A per-row mask word, with one bit per column, decides which keys may wake the system.

Top module: `kp_scan_engine`

## Requirements
- R1: Each pressed key yields one pulse of `key_valid` with `key_entry` = {bit 7 = 1, bits 6:3 = row number, bits 2:0 = column number}. Within a pass, entries come out in ascending row order, then ascending column order.
- R2: While scanning, at most one row line is low at a time. Rows are visited in ascending order. A row whose `row_active` bit is 0 is never driven low and adds no scan time.
- R3: Each visited row stays low for exactly 16 + `debounce_cnt` consecutive cycles (`debounce_cnt` is 10 bits, up to 1023).
- R4: The time from the first row of one pass going low to the first row of the next pass going low is 5 + (16 + `debounce_cnt`) × (number of active rows) + `repeat_cnt` cycles.
- R5: Dwell cycles are counted from 0. A key is reported only if its column is asserted in every dwell cycle from 7 through 7 + `debounce_cnt`. A deassertion inside that window suppresses the key for that pass. A deassertion outside the window has no effect.
- R6: When `scan_en` rises, the first active row goes low 6 clock edges later, after the 5-cycle lead-in. When `scan_en` falls, all rows are released after the next edge and no further entries are produced.
- R7: While `scan_en` is 0, each active row with at least one mask bit at 0 is driven low. A pressed key with mask bit 0 in such a row raises `wake_req` one cycle later.
- R8: A key whose mask bit is 1 raises no wake request, and a row whose mask word is all ones is not driven at all (given no other driven row leaves that column unmasked).
- R9: After reset, `key_valid` and `wake_req` are 0.
- R10: `wake_req` stays 0 while scanning is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock (about 32 kHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Global scan enable (control bit 0) |
| row_active | input | 16 | One bit per row: row is populated and scanned |
| debounce_cnt | input | 10 | Extra dwell and debounce cycles per row |
| repeat_cnt | input | 12 | Gap in cycles between passes |
| wake_mask | input | 128 | Row r mask word at bits [8r+7:8r]; bit c = 1 blocks key (r,c) from waking |
| col_in | input | 8 | Column sense inputs, 1 = key closed on a driven row |
| row_drive_n | output | 16 | Row drive lines, active low |
| key_valid | output | 1 | One-cycle strobe for `key_entry` |
| key_entry | output | 8 | Packed key entry {valid, row, column} |
| wake_req | output | 1 | Wake request while scanning is stopped |

## Verification
The bench builds the block with its default sizes: 16 rows, 8 columns, a 10-bit debounce field and a 12-bit repeat field. This lets it reach the full-size corners: the top row 15, column 7, a debounce of 1023 and a repeat of 4095, all inside one short run. A model of the key matrix closes each column from whichever row line is low. Pass period and dwell are measured on the row lines and compared with the formula. Single-cycle key releases are placed at the first and last sample cycles of the debounce window and just outside it.

// File: rtl/kp_pkg.sv
package kp_pkg;
    typedef enum logic [1:0] {
        KP_IDLE  = 2'd0,
        KP_START = 2'd1,
        KP_ROW   = 2'd2,
        KP_GAP   = 2'd3
    } kp_mode_e;
endpackage

// File: rtl/kp_row_pick.sv
// Finds the lowest active row whose index is at or above base.
module kp_row_pick #(
    parameter int NUM_ROWS = 16,
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic [NUM_ROWS-1:0] row_active,
    input  logic [ROW_W:0]      base,
    output logic                found,
    output logic [ROW_W-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (row_active[i] && ((ROW_W+1)'(i) >= base)) begin
                found = 1'b1;
                idx   = ROW_W'(i);
            end
        end
    end
endmodule

// File: rtl/kp_col_filter.sv
// Column accumulator: a column survives only if asserted on every sample.
module kp_col_filter #(
    parameter int NUM_COLS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                hold,
    input  logic [NUM_COLS-1:0] col_in,
    output logic [NUM_COLS-1:0] pressed_q
);
    logic [NUM_COLS-1:0] pressed_d;

    always_comb begin
        pressed_d = pressed_q;
        if (load)
            pressed_d = col_in;
        else if (hold)
            pressed_d = pressed_q & col_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pressed_q <= '0;
        else        pressed_q <= pressed_d;
    end
endmodule

// File: rtl/kp_wake_gate.sv
// Idle-time row drive and wake detection under the per-row masks.
module kp_wake_gate #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         idle,
    input  logic [NUM_ROWS-1:0]          row_active,
    input  logic [NUM_ROWS*NUM_COLS-1:0] wake_mask,
    input  logic [NUM_COLS-1:0]          col_in,
    output logic [NUM_ROWS-1:0]          drive_n,
    output logic                         wake_q
);
    logic [NUM_ROWS-1:0] row_on;
    logic [NUM_COLS-1:0] col_en;
    logic                wake_d;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_on[r] = row_active[r] & ~(&wake_mask[r*NUM_COLS +: NUM_COLS]);
    end

    always_comb begin
        col_en = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (row_on[r])
                col_en = col_en | ~wake_mask[r*NUM_COLS +: NUM_COLS];
        end
        drive_n = ~row_on;
        wake_d  = idle & (|(col_in & col_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_d;
    end
endmodule

// File: rtl/kp_scan_engine.sv
module kp_scan_engine
    import kp_pkg::*;
#(
    parameter int NUM_ROWS  = 16,
    parameter int NUM_COLS  = 8,
    parameter int DBNC_W    = 10,
    parameter int RPT_W     = 12,
    parameter int START_DLY = 5,
    parameter int SETTLE    = 7,
    localparam int ROW_W    = $clog2(NUM_ROWS),
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int ENT_W    = 1 + ROW_W + COL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scan_en,
    input  logic [NUM_ROWS-1:0]          row_active,
    input  logic [DBNC_W-1:0]            debounce_cnt,
    input  logic [RPT_W-1:0]             repeat_cnt,
    input  logic [NUM_ROWS*NUM_COLS-1:0] wake_mask,
    input  logic [NUM_COLS-1:0]          col_in,
    output logic [NUM_ROWS-1:0]          row_drive_n,
    output logic                         key_valid,
    output logic [ENT_W-1:0]             key_entry,
    output logic                         wake_req
);
    localparam int CNT_W = ((RPT_W > DBNC_W) ? RPT_W : DBNC_W) + 2;

    typedef struct packed {
        kp_mode_e             mode;
        logic [ROW_W-1:0]     row;
        logic [CNT_W-1:0]     cnt;
        logic                 kv;
        logic [ENT_W-1:0]     ke;
    } state_t;

    state_t q, d;

    logic [CNT_W-1:0]    db_ext, dwell_last, samp_last, emit_first, rpt_ext;
    logic                in_row, load, hold, emitting, pick_found;
    logic [COL_W-1:0]    col_sel;
    logic [ROW_W:0]      pick_base;
    logic [ROW_W-1:0]    pick_idx;
    logic [NUM_COLS-1:0] pressed_q;
    logic [NUM_ROWS-1:0] wake_drive_n;
    logic                scan_idle;

    assign scan_idle  = (q.mode == KP_IDLE);
    assign db_ext     = CNT_W'(debounce_cnt);
    assign rpt_ext    = CNT_W'(repeat_cnt);
    assign samp_last  = CNT_W'(SETTLE) + db_ext;
    assign emit_first = CNT_W'(SETTLE + 1) + db_ext;
    assign dwell_last = CNT_W'(SETTLE + NUM_COLS) + db_ext;
    assign in_row     = (q.mode == KP_ROW);
    assign load       = in_row && (q.cnt == CNT_W'(SETTLE));
    assign hold       = in_row && (q.cnt > CNT_W'(SETTLE)) && (q.cnt <= samp_last);
    assign emitting   = in_row && (q.cnt >= emit_first);
    assign col_sel    = COL_W'(q.cnt - emit_first);
    assign pick_base  = in_row ? ({1'b0, q.row} + 1'b1) : '0;

    kp_row_pick #(.NUM_ROWS(NUM_ROWS)) u_pick (
        .row_active (row_active),
        .base       (pick_base),
        .found      (pick_found),
        .idx        (pick_idx)
    );

    kp_col_filter #(.NUM_COLS(NUM_COLS)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .hold      (hold),
        .col_in    (col_in),
        .pressed_q (pressed_q)
    );

    kp_wake_gate #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (scan_idle),
        .row_active (row_active),
        .wake_mask  (wake_mask),
        .col_in     (col_in),
        .drive_n    (wake_drive_n),
        .wake_q     (wake_req)
    );

    always_comb begin
        d     = q;
        d.cnt = q.cnt + 1'b1;
        d.kv  = scan_en && emitting && pressed_q[col_sel];
        d.ke  = {1'b1, q.row, col_sel};
        unique case (q.mode)
            KP_IDLE: begin
                d.cnt = '0;
                if (scan_en) d.mode = KP_START;
            end
            KP_START, KP_ROW: begin
                if ((q.mode == KP_START && q.cnt >= CNT_W'(START_DLY - 1)) ||
                    (q.mode == KP_ROW && q.cnt >= dwell_last)) begin
                    d.cnt = '0;
                    if (pick_found) begin
                        d.mode = KP_ROW;
                        d.row  = pick_idx;
                    end else if (repeat_cnt == '0) begin
                        d.mode = KP_START;
                    end else begin
                        d.mode = KP_GAP;
                    end
                end
            end
            KP_GAP: begin
                if (q.cnt + 1'b1 >= rpt_ext) begin
                    d.cnt  = '0;
                    d.mode = KP_START;
                end
            end
            default: d.mode = KP_IDLE;
        endcase
        if (!scan_en) begin
            d.mode = KP_IDLE;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        row_drive_n = '1;
        if (q.mode == KP_ROW)
            row_drive_n[q.row] = 1'b0;
        else if (q.mode == KP_IDLE)
            row_drive_n = wake_drive_n;
    end

    assign key_valid = q.kv;
    assign key_entry = q.ke;
endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 8,
    localparam int ROW_W   = $clog2(NUM_ROWS),
    localparam int COL_W   = $clog2(NUM_COLS),
    localparam int ENT_W   = 1 + ROW_W + COL_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scan_en,
    input logic [NUM_ROWS-1:0] row_drive_n,
    input logic                key_valid,
    input logic [ENT_W-1:0]    key_entry,
    input logic                wake_req,
    input logic                scan_idle
);
    logic [NUM_ROWS-1:0] drv_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_prev <= '1;
        else        drv_prev <= row_drive_n;
    end

    // R2: a scanning pass never drives two rows together
    p_single_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_idle |-> $onehot0(~row_drive_n));

    // R1: an entry names the row that was low when it was sampled
    p_entry_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> !drv_prev[key_entry[COL_W +: ROW_W]]);

    // R6: no entries once the enable is low
    p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> !key_valid);

    // R10: wake only follows an idle cycle
    p_wake_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(scan_idle));
endmodule

bind kp_scan_engine kp_scan_checker #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .row_drive_n (row_drive_n),
    .key_valid   (key_valid),
    .key_entry   (key_entry),
    .wake_req    (wake_req),
    .scan_idle   (scan_idle)
);

// File: tb/kp_scan_engine_test.sv
module kp_scan_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int NC = 8;

    // {row_active[16], debounce[10], repeat[12], key_row[4], key_col[3]}
    localparam logic [44:0] VECS [0:5] = '{
        {16'hFFFF, 10'd0,    12'd0,    4'd0,  3'd0},
        {16'h0101, 10'd3,    12'd10,   4'd8,  3'd7},
        {16'h8000, 10'd20,   12'd5,    4'd15, 3'd3},
        {16'h00F0, 10'd1,    12'd0,    4'd5,  3'd2},
        {16'h0011, 10'd2,    12'd7,    4'd2,  3'd5},
        {16'h0003, 10'd1023, 12'd4095, 4'd1,  3'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scan_en = 1'b0;
    logic [NR-1:0]     row_active = '0;
    logic [9:0]        debounce_cnt = '0;
    logic [11:0]       repeat_cnt = '0;
    logic [NR*NC-1:0]  wake_mask = '1;
    logic [NC-1:0]     col_in;
    logic [NR-1:0]     row_drive_n;
    logic              key_valid;
    logic [7:0]        key_entry;
    logic              wake_req;
    logic [NR*NC-1:0]  keys = '0;

    int checks = 0, errors = 0;
    int cyc = 0, log_n = 0, stamp_n = 0, stamp_prev = 0, stamp_last = 0;
    int run = 0, last_run = 0, bad_drive = 0, watch_row = 0;
    logic [7:0] log_q [0:63];
    logic prev_hi = 1'b1, en_prev = 1'b0;

    kp_scan_engine uut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .row_active(row_active),
        .debounce_cnt(debounce_cnt), .repeat_cnt(repeat_cnt), .wake_mask(wake_mask),
        .col_in(col_in), .row_drive_n(row_drive_n), .key_valid(key_valid),
        .key_entry(key_entry), .wake_req(wake_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // key matrix: a closed key shorts its column to its row line when that row is low
    always_comb begin
        col_in = '0;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                if (keys[r*NC+c] && !row_drive_n[r]) col_in[c] = 1'b1;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (key_valid && log_n < 64) begin
                log_q[log_n] = key_entry;
                log_n++;
            end
            if (!row_drive_n[watch_row] && prev_hi) begin
                stamp_prev = stamp_last;
                stamp_last = cyc;
                stamp_n++;
            end
            if (!row_drive_n[watch_row]) run++;
            else if (run > 0) begin last_run = run; run = 0; end
            prev_hi = row_drive_n[watch_row];
            if (|(~row_drive_n & ~row_active)) bad_drive++;
            if (scan_en && en_prev && $countones(~row_drive_n) > 1) bad_drive++;
            en_prev = scan_en;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ent(input int r, input int c);
        return {1'b1, 4'(r), 3'(c)};
    endfunction

    task automatic arm(input int row);
        watch_row = row;
        log_n = 0; stamp_n = 0; run = 0; last_run = 0;
        prev_hi = row_drive_n[row];
    endtask

    // one pass with a single-cycle release of key (2,4) at dwell cycle 'at'
    task automatic glitch_pass(input int at, input bit expect_key, input string req);
        int s0;
        s0 = stamp_n;
        wait (stamp_n > s0);
        log_n = 0;
        repeat (at) @(negedge clk);
        #1 keys[2*NC+4] = 1'b0;
        tick(1);
        keys[2*NC+4] = 1'b1;
        wait (row_drive_n[2] == 1'b1);
        tick(2);
        check(log_n == (expect_key ? 1 : 0), req, log_n, expect_key ? 1 : 0);
        if (expect_key && log_n > 0)
            check(log_q[0] == ent(2, 4), req, log_q[0], ent(2, 4));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int act_rows, exp_period, low_row;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R9: reset state
        check(key_valid == 1'b0, "R9 key_valid after reset", key_valid, 0);
        check(wake_req == 1'b0, "R9 wake_req after reset", wake_req, 0);

        // vector table: R1 R2 R3 R4
        for (int v = 0; v < 6; v++) begin
            scan_en = 1'b0; keys = '0;
            tick(2);
            row_active   = VECS[v][44:29];
            debounce_cnt = VECS[v][28:19];
            repeat_cnt   = VECS[v][18:7];
            act_rows = $countones(row_active);
            low_row = 0;
            for (int r = NR - 1; r >= 0; r--) if (row_active[r]) low_row = r;
            exp_period = 5 + (16 + int'(debounce_cnt)) * act_rows + int'(repeat_cnt);
            keys[int'(VECS[v][6:3])*NC + int'(VECS[v][2:0])] = 1'b1;
            arm(low_row);
            scan_en = 1'b1;
            wait (stamp_n >= 2);
            #1;
            check(stamp_last - stamp_prev == exp_period, "R4 pass period",
                  stamp_last - stamp_prev, exp_period);
            check(last_run == 16 + int'(debounce_cnt), "R3 row dwell",
                  last_run, 16 + int'(debounce_cnt));
            if (row_active[VECS[v][6:3]]) begin
                check(log_n == 1, "R1 one entry per pass", log_n, 1);
                check(log_q[0] == ent(VECS[v][6:3], VECS[v][2:0]), "R1 entry format",
                      log_q[0], ent(VECS[v][6:3], VECS[v][2:0]));
            end else begin
                check(log_n == 0, "R2 inactive row skipped", log_n, 0);
            end
        end
        scan_en = 1'b0; keys = '0;
        tick(2);

        // R1 R2: ordering across rows and columns
        row_active = 16'hFFFF; debounce_cnt = 10'd0; repeat_cnt = 12'd0;
        keys[12*NC+4] = 1'b1; keys[3*NC+6] = 1'b1; keys[9*NC+0] = 1'b1; keys[3*NC+1] = 1'b1;
        arm(0);
        scan_en = 1'b1;
        wait (stamp_n >= 2);
        #1;
        check(log_n == 4, "R1 entry count", log_n, 4);
        check(log_q[0] == ent(3, 1), "R2 order 0", log_q[0], ent(3, 1));
        check(log_q[1] == ent(3, 6), "R2 order 1", log_q[1], ent(3, 6));
        check(log_q[2] == ent(9, 0), "R2 order 2", log_q[2], ent(9, 0));
        check(log_q[3] == ent(12, 4), "R2 order 3", log_q[3], ent(12, 4));
        // R10: no wake while scanning, even with unmasked keys
        wake_mask = '0;
        for (int i = 0; i < 100; i++) begin
            tick(1);
            if (wake_req) begin check(1'b0, "R10 wake during scan", 1, 0); break; end
        end
        check(wake_req == 1'b0, "R10 wake during scan", wake_req, 0);
        scan_en = 1'b0; keys = '0; wake_mask = '1;
        tick(2);

        // R5: debounce window edges, db = 3 -> samples at dwell cycles 7..10
        row_active = 16'h0004; debounce_cnt = 10'd3; repeat_cnt = 12'd0;
        keys[2*NC+4] = 1'b1;
        arm(2);
        scan_en = 1'b1;
        glitch_pass(6, 1'b1, "R5 release before window ignored");
        glitch_pass(7, 1'b0, "R5 release at first sample");
        glitch_pass(10, 1'b0, "R5 release at last sample");
        glitch_pass(11, 1'b1, "R5 release after window ignored");
        scan_en = 1'b0; keys = '0;
        tick(2);

        // R6: start latency and stop
        row_active = 16'h0001; debounce_cnt = 10'd0; repeat_cnt = 12'd0;
        keys[0*NC+3] = 1'b1;
        arm(0);
        scan_en = 1'b1;
        tick(5);
        check(row_drive_n[0] == 1'b1, "R6 lead-in rows high", row_drive_n[0], 1);
        tick(1);
        check(row_drive_n[0] == 1'b0, "R6 first row after lead-in", row_drive_n[0], 0);
        tick(2);
        scan_en = 1'b0;
        tick(1);
        check(row_drive_n == '1, "R6 rows released", row_drive_n, 16'hFFFF);
        tick(20);
        check(log_n == 0, "R6 no entries after stop", log_n, 0);

        // R7 R8: idle wake masking
        keys = '0;
        row_active = 16'hFFFF;
        wake_mask = '1;
        wake_mask[5*NC+2] = 1'b0;
        tick(2);
        check(row_drive_n == 16'hFFDF, "R7 idle drives unmasked row only", row_drive_n, 16'hFFDF);
        keys[5*NC+3] = 1'b1;
        tick(2);
        check(wake_req == 1'b0, "R8 masked key no wake", wake_req, 0);
        keys = '0; keys[7*NC+2] = 1'b1;
        tick(2);
        check(wake_req == 1'b0, "R8 fully masked row no wake", wake_req, 0);
        keys = '0; keys[5*NC+2] = 1'b1;
        tick(1);
        check(wake_req == 1'b1, "R7 unmasked key wakes", wake_req, 1);
        keys = '0;
        tick(2);
        check(wake_req == 1'b0, "R7 wake clears on release", wake_req, 0);

        check(bad_drive == 0, "R2 row drive discipline", bad_drive, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule